// File: doc/BRIEF.md
# Slice-wise scratch vector ALU

This engine operates on a scratch RAM that is split into equal slices. Both the slice size in bytes and the number of active slices are runtime configuration inputs. An arithmetic command names two source slices and a destination slice. The engine then walks the destination one 64-bit word at a time, starting at the top word and ending at word 0. For each word it stores the sum, the difference or the low half of the product of the matching source words. A clear command sets the whole active region to zero, working down from its highest byte.

The scratch RAM sits outside the block and is reached through a single-port, word-addressed synchronous interface. A read returns its data one cycle after it is issued. Writes carry per-byte enables. Slice `k` starts at byte address `k * slice_bytes`, which is word address `k * slice_bytes / 8`. The configuration and the command fields are captured when a command is accepted. A command is accepted only while `busy` is low. The end of every command, whether accepted or rejected, is marked by a one-cycle `done` pulse.

Top module: `slice_vec_alu`

## Requirements
- R1: With `cmd_op` = 0 (add), for every word offset `w` below `slice_bytes/8`, destination word `w` becomes source A word `w` plus source B word `w`, modulo 2^64. Slice `k` occupies word addresses `k*slice_bytes/8` upward.
- R2: With `cmd_op` = 1 (subtract), each destination word becomes source A minus source B, modulo 2^64.
- R3: With `cmd_op` = 2 (multiply), each destination word becomes the low 64 bits of source A times source B.
- R4: An arithmetic element is processed as a read of A, then a read of B, then a write of the destination. Elements go from the highest word of the slice down to word 0.
- R5: The destination index may equal a source index, and the result is the same as if all source words had been read before any write.
- R6: With `cmd_op` = 3 (clear), every byte of the first `slice_count*slice_bytes` bytes becomes zero. Writes go from the highest address down to word 0, and words beyond the region are left untouched.
- R7: When the cleared region is not a multiple of 8 bytes, the first clear write goes to word `total/8`. Its byte enable has only the low `total mod 8` bits set, so the bytes above the region in that word keep their values.
- R8: `busy` rises in the cycle after acceptance and falls in the cycle after the single-cycle `done` pulse. `done` comes 3n+1 cycles after acceptance for an n-word arithmetic command and W+1 cycles after acceptance for a clear that makes W writes.
- R9: An arithmetic command with a slice size of 0, or a clear over an empty region, completes with `done` one cycle after acceptance, makes no RAM write and does not raise `err`.
- R10: A command is rejected if the slice count exceeds the maximum, if the slice size exceeds the maximum, or if it is an arithmetic command whose slice size is not a multiple of 8 or whose slice index is not below the slice count. A rejected command raises `err` together with `done` one cycle after acceptance and writes nothing.
- R11: A command presented while `busy` is high is ignored: the running command keeps its timing and results, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 2 | 0 add, 1 subtract, 2 multiply, 3 clear |
| cmd_src_a | input | IDX_W | Index of the first source slice |
| cmd_src_b | input | IDX_W | Index of the second source slice |
| cmd_dst | input | IDX_W | Index of the destination slice |
| cfg_slice_bytes | input | SIZE_W | Slice size in bytes |
| cfg_slice_count | input | CNT_W | Number of active slices |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write (1) or read (0) |
| ram_addr | output | AW | RAM word address |
| ram_be | output | 8 | Byte enables for writes |
| ram_wdata | output | 64 | Write data |
| ram_rdata | input | 64 | Read data, valid the cycle after a read |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejection flag, high only with done |

## Verification
Arithmetic results are due at `done`, which comes 3n+1 cycles after the accepting edge. A clear is due W+1 cycles after that edge, and a rejected or empty command is due after one cycle. Each directed task counts falling edges from the accepting edge until `done`, compares the count with these figures, and only then compares the RAM image and the logged order of reads and writes against a model built from the requirements. The cycle after `done` is then checked for `busy` and `done` both low. The ignored-command scenario injects a clear in the second busy cycle and expects the unchanged 3n+1 timing and the unchanged arithmetic image.

// File: rtl/sva_pkg.sv
package sva_pkg;
    localparam int WORD_W = 64;
    localparam int BE_W   = WORD_W / 8;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_CLR = 2'd3
    } sva_op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RDA  = 3'd1,
        ST_RDB  = 3'd2,
        ST_WR   = 3'd3,
        ST_CLR  = 3'd4,
        ST_FIN  = 3'd5
    } sva_state_e;
endpackage

// File: rtl/sva_alu.sv
module sva_alu
    import sva_pkg::*;
(
    input  sva_op_e             op,
    input  logic [WORD_W-1:0]   opnd_a,
    input  logic [WORD_W-1:0]   opnd_b,
    output logic [WORD_W-1:0]   result
);
    always_comb begin
        unique case (op)
            OP_ADD:  result = opnd_a + opnd_b;
            OP_SUB:  result = opnd_a - opnd_b;
            OP_MUL:  result = opnd_a * opnd_b;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/sva_cmd_check.sv
module sva_cmd_check
    import sva_pkg::*;
#(
    parameter int MAX_SLICES      = 128,
    parameter int MAX_SLICE_BYTES = 4096
) (
    input  sva_op_e                                 op,
    input  logic [$clog2(MAX_SLICES)-1:0]           idx_a,
    input  logic [$clog2(MAX_SLICES)-1:0]           idx_b,
    input  logic [$clog2(MAX_SLICES)-1:0]           idx_d,
    input  logic [$clog2(MAX_SLICES+1)-1:0]         slice_count,
    input  logic [$clog2(MAX_SLICE_BYTES+1)-1:0]    slice_bytes,
    output logic                                    reject
);
    localparam int CNT_W  = $clog2(MAX_SLICES + 1);
    localparam int SIZE_W = $clog2(MAX_SLICE_BYTES + 1);

    logic cfg_bad;
    logic idx_bad;
    logic misaligned;

    always_comb begin
        cfg_bad    = (slice_count > CNT_W'(MAX_SLICES)) ||
                     (slice_bytes > SIZE_W'(MAX_SLICE_BYTES));
        idx_bad    = (CNT_W'(idx_a) >= slice_count) ||
                     (CNT_W'(idx_b) >= slice_count) ||
                     (CNT_W'(idx_d) >= slice_count);
        misaligned = (slice_bytes[2:0] != 3'd0);
        reject     = cfg_bad || ((op != OP_CLR) && (idx_bad || misaligned));
    end
endmodule

// File: rtl/slice_vec_alu.sv
module slice_vec_alu
    import sva_pkg::*;
#(
    parameter int MAX_SLICES      = 128,
    parameter int MAX_SLICE_BYTES = 4096,
    localparam int IDX_W     = $clog2(MAX_SLICES),
    localparam int CNT_W     = $clog2(MAX_SLICES + 1),
    localparam int SIZE_W    = $clog2(MAX_SLICE_BYTES + 1),
    localparam int TOT_BYTES = MAX_SLICES * MAX_SLICE_BYTES,
    localparam int AW        = $clog2(TOT_BYTES / 8)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [IDX_W-1:0]    cmd_src_a,
    input  logic [IDX_W-1:0]    cmd_src_b,
    input  logic [IDX_W-1:0]    cmd_dst,
    input  logic [SIZE_W-1:0]   cfg_slice_bytes,
    input  logic [CNT_W-1:0]    cfg_slice_count,
    output logic                ram_en,
    output logic                ram_we,
    output logic [AW-1:0]       ram_addr,
    output logic [7:0]          ram_be,
    output logic [63:0]         ram_wdata,
    input  logic [63:0]         ram_rdata,
    output logic                busy,
    output logic                done,
    output logic                err
);
    localparam int SLW_W = $clog2(MAX_SLICE_BYTES / 8 + 1);
    localparam int TOT_W = $clog2(TOT_BYTES + 1);

    typedef struct packed {
        sva_state_e         st;
        sva_op_e            op;
        logic [AW-1:0]      base_a;
        logic [AW-1:0]      base_b;
        logic [AW-1:0]      base_d;
        logic [SLW_W-1:0]   off;
        logic [AW-1:0]      ptr;
        logic [2:0]         tail;
        logic [WORD_W-1:0]  opa;
        logic               err;
    } regs_t;

    localparam regs_t REGS_RST = '0;

    regs_t q, d;

    sva_op_e            in_op;
    logic               reject;
    logic [SLW_W-1:0]   slice_words;
    logic [TOT_W-1:0]   total;
    logic [WORD_W-1:0]  alu_y;
    logic [BE_W-1:0]    tail_be;

    function automatic logic [AW-1:0] slice_base(input logic [IDX_W-1:0] idx,
                                                 input logic [SLW_W-1:0] words);
        return AW'(idx) * AW'(words);
    endfunction

    assign in_op = sva_op_e'(cmd_op);

    sva_cmd_check #(
        .MAX_SLICES      (MAX_SLICES),
        .MAX_SLICE_BYTES (MAX_SLICE_BYTES)
    ) u_check (
        .op          (in_op),
        .idx_a       (cmd_src_a),
        .idx_b       (cmd_src_b),
        .idx_d       (cmd_dst),
        .slice_count (cfg_slice_count),
        .slice_bytes (cfg_slice_bytes),
        .reject      (reject)
    );

    sva_alu u_alu (
        .op     (q.op),
        .opnd_a (q.opa),
        .opnd_b (ram_rdata),
        .result (alu_y)
    );

    always_comb begin
        slice_words = SLW_W'(cfg_slice_bytes >> 3);
        total       = TOT_W'(cfg_slice_count) * TOT_W'(cfg_slice_bytes);
        for (int i = 0; i < BE_W; i++) begin
            tail_be[i] = (3'(i) < q.tail);
        end
    end

    always_comb begin
        d         = q;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = '0;
        ram_be    = '0;
        ram_wdata = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.op  = in_op;
                    d.err = 1'b0;
                    if (reject) begin
                        d.err = 1'b1;
                        d.st  = ST_FIN;
                    end else if (in_op == OP_CLR) begin
                        if (total == '0) begin
                            d.st = ST_FIN;
                        end else begin
                            d.tail = total[2:0];
                            d.ptr  = (total[2:0] != 3'd0) ? AW'(total >> 3)
                                                           : AW'((total >> 3) - 1'b1);
                            d.st   = ST_CLR;
                        end
                    end else if (slice_words == '0) begin
                        d.st = ST_FIN;
                    end else begin
                        d.base_a = slice_base(cmd_src_a, slice_words);
                        d.base_b = slice_base(cmd_src_b, slice_words);
                        d.base_d = slice_base(cmd_dst, slice_words);
                        d.off    = slice_words - 1'b1;
                        d.st     = ST_RDA;
                    end
                end
            end
            ST_RDA: begin
                ram_en   = 1'b1;
                ram_addr = q.base_a + AW'(q.off);
                d.st     = ST_RDB;
            end
            ST_RDB: begin
                ram_en   = 1'b1;
                ram_addr = q.base_b + AW'(q.off);
                d.opa    = ram_rdata;
                d.st     = ST_WR;
            end
            ST_WR: begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_addr  = q.base_d + AW'(q.off);
                ram_be    = '1;
                ram_wdata = alu_y;
                if (q.off == '0) begin
                    d.st = ST_FIN;
                end else begin
                    d.off = q.off - 1'b1;
                    d.st  = ST_RDA;
                end
            end
            ST_CLR: begin
                ram_en   = 1'b1;
                ram_we   = 1'b1;
                ram_addr = q.ptr;
                ram_be   = (q.tail != 3'd0) ? tail_be : '1;
                d.tail   = 3'd0;
                if (q.ptr == '0) begin
                    d.st = ST_FIN;
                end else begin
                    d.ptr = q.ptr - 1'b1;
                end
            end
            ST_FIN: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    assign busy = (q.st != ST_IDLE);
    assign done = (q.st == ST_FIN);
    assign err  = (q.st == ST_FIN) && q.err;

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: the engine is free again right after done
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R8, R11: busy holds until the command finishes
    a_r11_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R10: err is only reported with done
    a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    // R4: RAM is touched only while a command runs
    a_r4_ram_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> busy);
    // R7: every write enables at least one byte
    a_r7_write_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_en && (ram_be != 8'd0)));
endmodule

// File: tb/tb_slice_vec_alu.sv
module tb_slice_vec_alu;
    localparam int MS  = 8;
    localparam int MB  = 64;
    localparam int IW  = 3;
    localparam int CW  = 4;
    localparam int SW  = 7;
    localparam int AWD = 6;
    localparam int NW  = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [1:0]     cmd_op = '0;
    logic [IW-1:0]  cmd_src_a = '0, cmd_src_b = '0, cmd_dst = '0;
    logic [SW-1:0]  cfg_slice_bytes = '0;
    logic [CW-1:0]  cfg_slice_count = '0;
    logic           ram_en, ram_we;
    logic [AWD-1:0] ram_addr;
    logic [7:0]     ram_be;
    logic [63:0]    ram_wdata;
    logic [63:0]    ram_rdata = '0;
    logic           busy, done, err;

    slice_vec_alu #(.MAX_SLICES(MS), .MAX_SLICE_BYTES(MB)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_dst(cmd_dst),
        .cfg_slice_bytes(cfg_slice_bytes), .cfg_slice_count(cfg_slice_count),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .busy(busy), .done(done), .err(err)
    );

    always #2 clk = ~clk;

    logic [63:0] mem [0:NW-1];
    logic [63:0] expv [0:NW-1];
    int          wlog [0:255];
    logic [7:0]  wbe  [0:255];
    int          rlog [0:255];
    int          wcnt = 0;
    int          rcnt = 0;
    int          errors = 0;
    int          checks = 0;
    bit          finished = 1'b0;

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) begin
                for (int b = 0; b < 8; b++)
                    if (ram_be[b]) mem[ram_addr][8*b +: 8] = ram_wdata[8*b +: 8];
                if (wcnt < 256) begin wlog[wcnt] = int'(ram_addr); wbe[wcnt] = ram_be; end
                wcnt++;
            end else begin
                ram_rdata <= mem[ram_addr];
                if (rcnt < 256) rlog[rcnt] = int'(ram_addr);
                rcnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic fill();
        for (int w = 0; w < NW; w++)
            mem[w] = (64'(w + 1) * 64'hD1B5_4A32_D192_ED03) ^ 64'(w);
        mem[8]  = 64'hFFFF_FFFF_FFFF_FFFF;
        mem[16] = 64'h0000_0000_0000_0002;
    endtask

    task automatic snap();
        for (int w = 0; w < NW; w++) expv[w] = mem[w];
    endtask

    task automatic compare_mem(input string req);
        int bad = 0; int first = -1;
        for (int w = 0; w < NW; w++)
            if (mem[w] !== expv[w]) begin bad++; if (first < 0) first = w; end
        if (first < 0) check(1'b1, req, 0, 0);
        else check(1'b0, req, longint'(mem[first]), longint'(expv[first]));
    endtask

    // runs one command; returns cycles from accepting edge to done
    task automatic run(input int op, input int a, input int b, input int dd,
                       input int cnt, input int bytes, input bit inject,
                       output int cyc, output bit err_seen);
        @(negedge clk);
        cmd_op = 2'(op); cmd_src_a = IW'(a); cmd_src_b = IW'(b); cmd_dst = IW'(dd);
        cfg_slice_count = CW'(cnt); cfg_slice_bytes = SW'(bytes);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 1; err_seen = 1'b0;
        while (!done && cyc < 2000) begin
            if (inject && cyc == 2) begin
                cmd_op = 2'd3; cmd_valid = 1'b1;
            end
            @(negedge clk);
            cmd_valid = 1'b0;
            if (inject) begin cmd_op = 2'(op); end
            cyc++;
        end
        err_seen = err;
        @(negedge clk);
        check(!busy && !done, "R8 release", {62'd0, busy, done}, 0);
    endtask

    function automatic logic [63:0] model(input int op, input logic [63:0] x, input logic [63:0] y);
        case (op)
            0: return x + y;
            1: return x - y;
            default: return x * y;
        endcase
    endfunction

    task automatic t_arith(input int op, input int a, input int b, input int dd,
                           input int cnt, input int bytes, input bit inject, input string req);
        int cyc; bit e; int n; int w0; int r0;
        n = bytes / 8;
        snap();
        for (int w = 0; w < n; w++)
            expv[dd*n + w] = model(op, mem[a*n + w], mem[b*n + w]);
        w0 = wcnt; r0 = rcnt;
        run(op, a, b, dd, cnt, bytes, inject, cyc, e);
        check(cyc == 3*n + 1, {req, " R8 timing"}, cyc, 3*n + 1);
        check(!e, {req, " no err"}, e, 0);
        compare_mem(req);
        check(wcnt - w0 == n, {req, " write count"}, wcnt - w0, n);
        check(wlog[w0] == dd*n + n - 1 && wlog[w0 + n - 1] == dd*n,
              "R4 write order", wlog[w0], dd*n + n - 1);
        check(rlog[r0] == a*n + n - 1 && rlog[r0 + 1] == b*n + n - 1,
              "R4 read order", rlog[r0 + 1], b*n + n - 1);
    endtask

    task automatic t_reject(input int op, input int a, input int b, input int dd,
                            input int cnt, input int bytes, input string req);
        int cyc; bit e; int w0;
        snap(); w0 = wcnt;
        run(op, a, b, dd, cnt, bytes, 1'b0, cyc, e);
        check(cyc == 1, {req, " timing"}, cyc, 1);
        check(e, {req, " err"}, e, 1);
        check(wcnt == w0, {req, " no writes"}, wcnt - w0, 0);
        compare_mem(req);
    endtask

    task automatic t_zero();
        int cyc; bit e; int w0;
        snap(); w0 = wcnt;
        run(0, 1, 2, 3, 8, 0, 1'b0, cyc, e);
        check(cyc == 1 && !e, "R9 zero size", cyc, 1);
        check(wcnt == w0, "R9 no writes", wcnt - w0, 0);
        run(3, 0, 0, 0, 0, 64, 1'b0, cyc, e);
        check(cyc == 1 && !e && wcnt == w0, "R9 empty clear", cyc, 1);
    endtask

    task automatic t_clear(input int cnt, input int bytes, input string req);
        int cyc; bit e; int w0; int tot; int nwr; int full; int tl;
        tot = cnt * bytes; full = tot / 8; tl = tot % 8;
        nwr = full + (tl != 0 ? 1 : 0);
        snap();
        for (int w = 0; w < full; w++) expv[w] = '0;
        for (int bb = 0; bb < tl; bb++) expv[full][8*bb +: 8] = 8'h00;
        w0 = wcnt;
        run(3, 0, 0, 0, cnt, bytes, 1'b0, cyc, e);
        check(cyc == nwr + 1, {req, " R8 timing"}, cyc, nwr + 1);
        check(!e && wcnt - w0 == nwr, {req, " writes"}, wcnt - w0, nwr);
        check(wlog[w0] == nwr - 1 && wlog[w0 + nwr - 1] == 0, {req, " order"}, wlog[w0], nwr - 1);
        if (tl != 0)
            check(wbe[w0] == 8'((1 << tl) - 1), "R7 tail byte enable", wbe[w0], (1 << tl) - 1);
        compare_mem(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        fill();
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !ram_en, "R8 reset state",
              {60'd0, busy, done, err, ram_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_arith(0, 1, 2, 3, 8, 64, 1'b0, "R1 add");
        t_arith(1, 4, 5, 6, 8, 64, 1'b0, "R2 subtract");
        t_arith(2, 2, 7, 0, 8, 64, 1'b0, "R3 multiply");
        t_arith(0, 0, 4, 2, 5, 24, 1'b0, "R1 add small slices");
        t_arith(1, 1, 2, 1, 8, 64, 1'b0, "R5 alias dst=a");
        t_arith(2, 6, 6, 6, 8, 64, 1'b0, "R5 alias all");
        t_arith(0, 1, 2, 3, 8, 64, 1'b1, "R11 ignore while busy");
        t_zero();
        t_reject(0, 1, 2, 5, 4, 64, "R10 index over count");
        t_reject(1, 6, 2, 1, 4, 64, "R10 source over count");
        t_reject(0, 1, 2, 3, 8, 20, "R10 misaligned size");
        t_reject(3, 0, 0, 0, 9, 64, "R10 count over max");
        t_reject(2, 0, 1, 2, 4, 72, "R10 size over max");
        fill();
        t_clear(3, 20, "R6 R7 clear tail");
        t_clear(8, 64, "R6 clear all");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule